// File: doc/BRIEF.md
# Eight-bit ALU with status flags

This block is the arithmetic and logic datapath of an 8-bit accumulator machine. Each cycle in which `op_valid` is high, it takes an operation code, the accumulator byte and a second operand byte. It produces the new result byte at once, along with a write-enable that tells the register file whether to store that byte. It also produces the next value of the flag byte. The flag byte sits in a register inside the block. Its carry and half-carry bits are the carry-in for the operations that need them.

The set of operations covers the following:
- add and subtract, each with or without the stored carry;
- increment and decrement of the operand byte;
- bitwise AND, XOR and OR;
- compare, which changes only the flags;
- four single-bit rotates;
- setting and inverting the carry;
- inverting the accumulator;
- decimal correction to packed BCD after an addition.

Opcode decode, the register file and any sequencing across cycles belong to the surrounding core.

Top module: `alu8_core`

## Requirements
- R1: After reset `flags_q` is 00h. The flag byte holds sign at bit 7, zero at bit 6, half carry at bit 4, parity at bit 2 and carry at bit 0. Bits 5, 3 and 1 always read 0.
- R2: Code 0 (add) and code 1 (add with carry) give acc+opnd (+CY) mod 256 with write-enable set. CY is the carry out of bit 7, and AC is the carry out of bit 3. S is result bit 7. Z is set only for a zero result. P is set for an even count of 1 bits.
- R3: Code 2 (subtract) and code 3 (subtract with borrow) give acc-opnd (-CY) mod 256 with write-enable set. CY is set on a borrow. AC is the carry out of bit 3 of acc + ~opnd + (1 - borrow-in). S, Z and P follow R2.
- R4: Code 7 (compare) sets the flags exactly as code 2 would and leaves write-enable low.
- R5: Code 8 gives opnd+1, and code 9 gives opnd-1, each with write-enable set. S, Z and P follow R2. AC is set for increment when the low nibble of opnd is Fh, and for decrement when it is nonzero. CY keeps its stored value.
- R6: Code 4 (AND), code 5 (XOR) and code 6 (OR) combine acc with opnd. CY and AC are cleared, and S, Z and P follow R2.
- R7: The rotates each shift acc by one bit and change only CY.
  - Code 10 rotates left, and bit 7 wraps to bit 0 and goes to CY.
  - Code 11 rotates right, and bit 0 wraps to bit 7 and goes to CY.
  - Code 12 rotates left through CY.
  - Code 13 rotates right through CY.
- R8: Code 15 writes ~acc and leaves every flag unchanged. Code 16 sets CY, and code 17 inverts CY. Both leave write-enable low and the other flags unchanged.
- R9: Code 14 performs decimal correction in two steps:
  - First it adds 06h if the low nibble of acc exceeds 9 or AC is set. AC becomes the carry out of bit 3 of that addition.
  - It then adds 60h, and sets CY, if the high nibble of the partial sum exceeds 9, if that addition carried out of bit 7, or if CY was set. Otherwise CY is cleared.
  - S, Z and P follow R2, and write-enable is set.
- R10: Codes 18 to 31, and any cycle with `op_valid` low, leave write-enable low and make `flags_next` equal `flags_q`.
- R11: On each rising clock edge `flags_q` takes the value of `flags_next`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 5 | Operation code |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Second operand byte |
| res_out | output | 8 | Result byte |
| res_we | output | 1 | Store the result byte |
| flags_next | output | 8 | Flag byte that loads at the next edge |
| flags_q | output | 8 | Current flag byte |

## Verification
The assertions assume `op_sel` and `op_valid` are stable, defined values for the whole clock period, so the result and flags settle before the edge. The bench drives every input on the falling edge and samples one time step later.

Before each checked operation, the bench loads a known carry and half-carry through an addition with a chosen pair of operands. The flag register therefore never holds a value that is unknown to the bench. This gives the carry-dependent operations, and decimal correction, all four carry-in combinations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_XOR = 5'd5,
        OP_OR  = 5'd6,
        OP_CMP = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_RLC = 5'd10,
        OP_RRC = 5'd11,
        OP_RAL = 5'd12,
        OP_RAR = 5'd13,
        OP_DAA = 5'd14,
        OP_CMA = 5'd15,
        OP_STC = 5'd16,
        OP_CMC = 5'd17
    } alu_op_e;

    // Packed so that each field lands on its fixed bit position.
    typedef struct packed {
        logic s;
        logic z;
        logic rsv5;
        logic ac;
        logic rsv3;
        logic p;
        logic rsv1;
        logic cy;
    } flag_t;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              we;
        flag_t             flags;
    } alu_out_t;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cin_i,
    input  logic              sub_i,
    output logic [DATA_W-1:0] sum_o,
    output logic              cout_o,
    output logic              hc_o
);
    localparam int NIB = DATA_W / 2;

    logic [DATA_W-1:0] bx;
    logic              cx;
    logic [NIB:0]      lo_sum;
    logic [NIB:0]      hi_sum;

    // Subtraction is an add of the inverted operand with an inverted carry-in.
    always_comb begin
        bx     = sub_i ? ~b_i : b_i;
        cx     = sub_i ? ~cin_i : cin_i;
        lo_sum = {1'b0, a_i[NIB-1:0]} + {1'b0, bx[NIB-1:0]} + {{NIB{1'b0}}, cx};
        hi_sum = {1'b0, a_i[DATA_W-1:NIB]} + {1'b0, bx[DATA_W-1:NIB]}
               + {{NIB{1'b0}}, lo_sum[NIB]};
        sum_o  = {hi_sum[NIB-1:0], lo_sum[NIB-1:0]};
        cout_o = hi_sum[NIB];
        hc_o   = lo_sum[NIB];
    end

endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] res_o,
    output logic              cy_o
);
    always_comb begin
        res_o = a_i;
        cy_o  = cy_i;
        unique case (op_i)
            OP_AND:  begin res_o = a_i & b_i; cy_o = 1'b0; end
            OP_XOR:  begin res_o = a_i ^ b_i; cy_o = 1'b0; end
            OP_OR:   begin res_o = a_i | b_i; cy_o = 1'b0; end
            OP_RLC:  begin res_o = {a_i[DATA_W-2:0], a_i[DATA_W-1]}; cy_o = a_i[DATA_W-1]; end
            OP_RRC:  begin res_o = {a_i[0], a_i[DATA_W-1:1]};        cy_o = a_i[0]; end
            OP_RAL:  begin res_o = {a_i[DATA_W-2:0], cy_i};          cy_o = a_i[DATA_W-1]; end
            OP_RAR:  begin res_o = {cy_i, a_i[DATA_W-1:1]};          cy_o = a_i[0]; end
            OP_CMA:  begin res_o = ~a_i; end
            OP_STC:  begin cy_o = 1'b1; end
            OP_CMC:  begin cy_o = ~cy_i; end
            default: begin res_o = a_i; cy_o = cy_i; end
        endcase
    end

endmodule

// File: rtl/alu8_bcd_fix.sv
module alu8_bcd_fix #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_i,
    input  logic              ac_i,
    input  logic              cy_i,
    output logic [DATA_W-1:0] res_o,
    output logic              ac_o,
    output logic              cy_o
);
    localparam int NIB = DATA_W / 2;
    localparam logic [NIB-1:0]  DIGIT_MAX = NIB'(9);
    localparam logic [DATA_W:0] LO_FIX    = (DATA_W+1)'(6);
    localparam logic [DATA_W-1:0] HI_FIX  = DATA_W'(6 << NIB);

    logic          lo_adj;
    logic          hi_adj;
    logic [NIB:0]  lo_sum;
    logic [DATA_W:0] part;

    always_comb begin
        lo_adj = (a_i[NIB-1:0] > DIGIT_MAX) | ac_i;
        lo_sum = {1'b0, a_i[NIB-1:0]} + (lo_adj ? LO_FIX[NIB:0] : '0);
        part   = {1'b0, a_i} + (lo_adj ? LO_FIX : '0);
        hi_adj = part[DATA_W] | cy_i | (part[DATA_W-1:NIB] > DIGIT_MAX);
        res_o  = part[DATA_W-1:0] + (hi_adj ? HI_FIX : '0);
        ac_o   = lo_sum[NIB];
        cy_o   = hi_adj;
    end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [4:0]        op_sel,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    output logic [DATA_W-1:0] res_out,
    output logic              res_we,
    output logic [7:0]        flags_next,
    output logic [7:0]        flags_q
);
    alu_op_e  op_e;
    flag_t    flags_d;
    flag_t    flag_r_q;
    alu_out_t out_d;

    logic [DATA_W-1:0] add_a_d, add_b_d, add_sum;
    logic              add_cin_d, add_sub_d, add_cout, add_hc;
    logic [DATA_W-1:0] bit_res;
    logic              bit_cy;
    logic [DATA_W-1:0] bcd_res;
    logic              bcd_ac, bcd_cy;

    assign op_e = alu_op_e'(op_sel);

    // Operand routing into the shared adder.
    always_comb begin
        add_a_d   = acc_in;
        add_b_d   = opnd_in;
        add_cin_d = 1'b0;
        add_sub_d = 1'b0;
        unique case (op_e)
            OP_ADC: add_cin_d = flag_r_q.cy;
            OP_SUB, OP_CMP: add_sub_d = 1'b1;
            OP_SBB: begin add_sub_d = 1'b1; add_cin_d = flag_r_q.cy; end
            OP_INC: begin add_a_d = opnd_in; add_b_d = '0; add_cin_d = 1'b1; end
            OP_DEC: begin add_a_d = opnd_in; add_b_d = DATA_W'(1); add_sub_d = 1'b1; end
            default: ;
        endcase
    end

    alu8_addsub #(.DATA_W(DATA_W)) addsub_i (
        .a_i(add_a_d), .b_i(add_b_d), .cin_i(add_cin_d), .sub_i(add_sub_d),
        .sum_o(add_sum), .cout_o(add_cout), .hc_o(add_hc)
    );

    alu8_bitops #(.DATA_W(DATA_W)) bitops_i (
        .op_i(op_e), .a_i(acc_in), .b_i(opnd_in), .cy_i(flag_r_q.cy),
        .res_o(bit_res), .cy_o(bit_cy)
    );

    alu8_bcd_fix #(.DATA_W(DATA_W)) bcd_i (
        .a_i(acc_in), .ac_i(flag_r_q.ac), .cy_i(flag_r_q.cy),
        .res_o(bcd_res), .ac_o(bcd_ac), .cy_o(bcd_cy)
    );

    // Next result, write-enable and flag byte.
    always_comb begin
        logic upd_szp;
        logic [DATA_W-1:0] r;
        out_d   = '0;
        out_d.flags = flag_r_q;
        upd_szp = 1'b0;
        r       = '0;
        if (op_valid) begin
            unique case (op_e)
                OP_ADD, OP_ADC: begin
                    r = add_sum; out_d.we = 1'b1; upd_szp = 1'b1;
                    out_d.flags.cy = add_cout; out_d.flags.ac = add_hc;
                end
                OP_SUB, OP_SBB, OP_CMP: begin
                    r = add_sum; out_d.we = (op_e != OP_CMP); upd_szp = 1'b1;
                    out_d.flags.cy = ~add_cout; out_d.flags.ac = add_hc;
                end
                OP_INC, OP_DEC: begin
                    r = add_sum; out_d.we = 1'b1; upd_szp = 1'b1;
                    out_d.flags.ac = add_hc;
                end
                OP_AND, OP_XOR, OP_OR: begin
                    r = bit_res; out_d.we = 1'b1; upd_szp = 1'b1;
                    out_d.flags.cy = 1'b0; out_d.flags.ac = 1'b0;
                end
                OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                    r = bit_res; out_d.we = 1'b1; out_d.flags.cy = bit_cy;
                end
                OP_CMA: begin
                    r = bit_res; out_d.we = 1'b1;
                end
                OP_STC, OP_CMC: begin
                    out_d.flags.cy = bit_cy;
                end
                OP_DAA: begin
                    r = bcd_res; out_d.we = 1'b1; upd_szp = 1'b1;
                    out_d.flags.cy = bcd_cy; out_d.flags.ac = bcd_ac;
                end
                default: ;
            endcase
        end
        out_d.res = r;
        if (upd_szp) begin
            out_d.flags.s = r[DATA_W-1];
            out_d.flags.z = (r == '0);
            out_d.flags.p = ~^r;
        end
        out_d.flags.rsv5 = 1'b0;
        out_d.flags.rsv3 = 1'b0;
        out_d.flags.rsv1 = 1'b0;
        flags_d = out_d.flags;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_r_q <= '0;
        else        flag_r_q <= flags_d;
    end

    assign res_out    = out_d.res;
    assign res_we     = out_d.we;
    assign flags_next = flags_d;
    assign flags_q    = flag_r_q;

    a_r1_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[5] == 1'b0) && (flags_q[3] == 1'b0) && (flags_q[1] == 1'b0));

    a_r4_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 5'd7) |-> !res_we);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(flags_q));

    a_r5_cy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && (op_sel == 5'd8 || op_sel == 5'd9)) |=> flags_q[0] == $past(flags_q[0]));

    a_r8_stc_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 5'd16) |=> flags_q[0]);

    a_r2_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel <= 5'd9 && op_sel != 5'd7) |-> (flags_next[6] == (res_out == '0)));

endmodule

// File: tb/alu8_core_tb_top.sv
module alu8_core_tb_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [4:0] op_sel;
    logic [7:0] acc_in, opnd_in;
    logic [7:0] res_out, flags_next, flags_q;
    logic       res_we;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [7:0] model_flags;

    always #5 clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .acc_in(acc_in), .opnd_in(opnd_in), .res_out(res_out), .res_we(res_we),
        .flags_next(flags_next), .flags_q(flags_q)
    );

    function automatic int even_ones(input int v);
        int n = 0;
        for (int i = 0; i < 8; i++) n += (v >> i) & 1;
        return (n % 2 == 0) ? 1 : 0;
    endfunction

    // Returns {write-enable, result, flag byte}.
    function automatic logic [16:0] model(input int op, input int a, input int b, input logic [7:0] f);
        int cy, ac, r, s, c, nac, ncy, add1, t;
        bit we, full;
        logic [7:0] nf;
        cy = f[0]; ac = f[4]; r = a; nac = ac; ncy = cy; we = 1; full = 0;
        case (op)
            0, 1: begin
                c = (op == 1) ? cy : 0; s = a + b + c;
                r = s & 255; ncy = (s > 255); nac = (((a & 15) + (b & 15) + c) > 15); full = 1;
            end
            2, 3, 7: begin
                c = (op == 3) ? cy : 0; s = a - b - c;
                r = s & 255; ncy = (s < 0); nac = (((a & 15) + ((~b) & 15) + (1 - c)) > 15);
                full = 1; we = (op != 7);
            end
            4: begin r = a & b; ncy = 0; nac = 0; full = 1; end
            5: begin r = a ^ b; ncy = 0; nac = 0; full = 1; end
            6: begin r = a | b; ncy = 0; nac = 0; full = 1; end
            8: begin r = (b + 1) & 255; nac = ((b & 15) == 15); full = 1; end
            9: begin r = (b + 255) & 255; nac = ((b & 15) != 0); full = 1; end
            10: begin r = ((a << 1) | (a >> 7)) & 255; ncy = (a >> 7) & 1; end
            11: begin r = ((a >> 1) | ((a & 1) << 7)) & 255; ncy = a & 1; end
            12: begin r = ((a << 1) | cy) & 255; ncy = (a >> 7) & 1; end
            13: begin r = ((a >> 1) | (cy << 7)) & 255; ncy = a & 1; end
            14: begin
                add1 = (((a & 15) > 9) || ac) ? 6 : 0;
                t = a + add1; nac = (((a & 15) + add1) > 15);
                ncy = ((((t >> 4) & 15) > 9) || cy || (t > 255)) ? 1 : 0;
                r = (t + (ncy ? 96 : 0)) & 255; full = 1;
            end
            15: r = (~a) & 255;
            16: begin we = 0; ncy = 1; end
            17: begin we = 0; ncy = 1 - cy; end
            default: we = 0;
        endcase
        nf = f;
        nf[0] = ncy[0];
        nf[4] = nac[0];
        if (full) begin
            nf[7] = r[7];
            nf[6] = (r == 0);
            nf[2] = even_ones(r) != 0;
        end
        return {we, r[7:0], nf};
    endfunction

    task automatic fail_line(input string req, input logic [16:0] act, input logic [16:0] exp);
        errors++;
        $display("FAIL %s op=%0d acc=%02h opnd=%02h actual we=%0b res=%02h flags=%02h expected we=%0b res=%02h flags=%02h",
                 req, op_sel, acc_in, opnd_in, act[16], act[15:8], act[7:0], exp[16], exp[15:8], exp[7:0]);
    endtask

    task automatic chk_out(input string req, input logic [16:0] exp);
        logic [16:0] act;
        act = {res_we, res_out, flags_next};
        checks++;
        if (act[16] !== exp[16] || act[7:0] !== exp[7:0] || (exp[16] && act[15:8] !== exp[15:8]))
            fail_line(req, act, exp);
    endtask

    task automatic chk_flags_q(input string req, input logic [7:0] exp);
        checks++;
        if (flags_q !== exp) fail_line(req, {1'b0, 8'h00, flags_q}, {1'b0, 8'h00, exp});
    endtask

    // Load a known carry / half carry through an addition; R11 check on the edge.
    task automatic prime(input int pcy, input int pac);
        int pa, pb;
        pa = pcy ? (pac ? 8'h88 : 8'h80) : (pac ? 8'h08 : 8'h00);
        pb = pa;
        op_valid = 1'b1; op_sel = 5'd0; acc_in = pa[7:0]; opnd_in = pb[7:0];
        @(posedge clk); #1;
        model_flags = model(0, pa, pb, 8'h00)[7:0];
        chk_flags_q("R11", model_flags);
        @(negedge clk);
    endtask

    task automatic run_vec(input string req, input int op, input int a, input int b, input int pcy, input int pac);
        prime(pcy, pac);
        op_valid = 1'b1; op_sel = op[4:0]; acc_in = a[7:0]; opnd_in = b[7:0];
        #1;
        chk_out(req, model(op, a, b, model_flags));
    endtask

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_sel = '0; acc_in = '0; opnd_in = '0;
        repeat (3) @(posedge clk);
        #1;
        chk_flags_q("R1", 8'h00);
        checks++;
        if (res_we !== 1'b0) fail_line("R1", {res_we, res_out, flags_next}, 17'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 / R3 / R4: add, subtract and compare, both carry-in values.
        for (int op = 0; op < 8; op++) begin
            if (op >= 4 && op <= 6) continue;
            for (int cy = 0; cy < 2; cy++)
                for (int a = 0; a < 256; a++)
                    for (int j = 0; j < 16; j++)
                        run_vec(op < 2 ? "R2" : (op == 7 ? "R4" : "R3"), op, a, (j * 17 + a * 3) & 255, cy, cy);
        end

        // R6: logical operations.
        for (int op = 4; op <= 6; op++)
            for (int a = 0; a < 256; a++)
                for (int j = 0; j < 16; j++)
                    run_vec("R6", op, a, (j * 17 + a * 5) & 255, (a + j) & 1, a & 1);

        // R5: increment / decrement, CY kept.
        for (int op = 8; op <= 9; op++)
            for (int b = 0; b < 256; b++)
                run_vec("R5", op, (b * 7) & 255, b, b & 1, (b >> 1) & 1);

        // R7: rotates with both carry values.
        for (int op = 10; op <= 13; op++)
            for (int cy = 0; cy < 2; cy++)
                for (int a = 0; a < 256; a++)
                    run_vec("R7", op, a, 0, cy, a & 1);

        // R9: decimal correction under all four carry/half-carry settings.
        for (int k = 0; k < 4; k++)
            for (int a = 0; a < 256; a++)
                run_vec("R9", 14, a, 0, k & 1, k >> 1);

        // R8: invert accumulator, set / invert carry.
        for (int op = 15; op <= 17; op++)
            for (int k = 0; k < 4; k++)
                run_vec("R8", op, 8'h5A + k, 0, k & 1, k >> 1);

        // R10: unassigned codes.
        for (int op = 18; op < 32; op++)
            run_vec("R10", op, 8'hFF, 8'h01, 1, 1);

        // R10: op_valid low leaves flags and write-enable alone, across an edge.
        prime(1, 1);
        op_valid = 1'b0; op_sel = 5'd16; acc_in = 8'h00; opnd_in = 8'h00;
        #1;
        chk_out("R10", {1'b0, 8'h00, model_flags});
        @(posedge clk); #1;
        chk_flags_q("R10", model_flags);
        @(negedge clk);

        // R11: a decrement result registers, CY unchanged (R5).
        prime(1, 0);
        op_valid = 1'b1; op_sel = 5'd9; acc_in = 8'h00; opnd_in = 8'h00;
        #1;
        begin
            logic [16:0] e;
            e = model(9, 0, 0, model_flags);
            @(posedge clk); #1;
            chk_flags_q("R11", e[7:0]);
        end
        @(negedge clk);
        op_valid = 1'b0;

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule